// File: doc/BRIEF.md
# Power-On Fail-Safe Fan Sequencer

This block decides how the device behaves after power-up. It combines two things: whether the processor core rail is live, and whether the host has yet addressed the device over the management bus. Three inputs drive it:

- a rail-present flag, which is high when the core rail sits above 0.75 V;
- a single-cycle pulse for each valid bus access;
- a timebase tick.

From these it produces four outputs: a one-shot strobe that loads the default register settings, a level that drives every fan to full speed, a one-shot that stops the fans, and a level flag for normal operation.

After reset the sequencer polls the rail for one cycle (state POLL).

- **Rail down.** The sequencer goes to WAIT (edge POLL→WAIT). It stays there until a bus access arrives (WAIT→RUN). If the rail rises first, it moves to COUNT (WAIT→COUNT).
- **Rail up.** The sequencer goes to COUNT (edge POLL→COUNT) and counts timebase ticks up to `TIMEOUT_TICKS`. With a 1 ms tick, the default of 4600 gives about 4.6 s.
  - A bus access during the count leads straight to normal operation (COUNT→RUN).
  - If the count runs out first, the fans are forced to full speed (COUNT→FULL).
  - A later access stops the fans and starts normal operation (FULL→RUN).
- **Early access.** A bus access during POLL itself goes directly to RUN (POLL→RUN).

RUN is held until reset.

Top module: `fsf_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after its release, all four outputs are low.
- R2: On the first cycle after reset, a low rail selects the waiting branch and a high rail selects the countdown branch. A bus access in that cycle selects normal operation directly.
- R3: In the waiting branch, no number of ticks asserts fan_full. A bus access moves the block to normal operation, with load_dflt high for one cycle and run_normal high from that cycle on.
- R4: In the countdown branch, a bus access made after fewer than TIMEOUT_TICKS ticks leads to normal operation without fan_full ever rising.
- R5: Once TIMEOUT_TICKS ticks have been counted with no access, fan_full rises one cycle later and stays high until a bus access.
- R6: A bus access while fans are forced gives fan_stop and load_dflt for one cycle, drops fan_full and raises run_normal, all in the cycle after the access.
- R7: load_dflt is a single-cycle pulse that is issued exactly once between resets.
- R8: Once run_normal is high, later accesses, ticks and rail changes leave run_normal high and load_dflt and fan_full low until reset.
- R9: If the rail rises while waiting, the block enters the countdown, and the timeout then forces the fans as in R5.
- R10: A bus access in the same cycle as the countdown reaching TIMEOUT_TICKS wins. The block goes to normal operation, with no fan_full and no fan_stop.
- R11: The countdown advances only on cycles where tick is high. Cycles without a tick do not bring the timeout closer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rail_up | input | 1 | Processor core rail above 0.75 V |
| bus_hit | input | 1 | One-cycle pulse per valid management-bus access |
| tick | input | 1 | Timebase tick, one cycle per timeout unit |
| load_dflt | output | 1 | One-cycle strobe: load default register settings |
| fan_full | output | 1 | Drive all fans to full speed |
| fan_stop | output | 1 | One-cycle strobe: stop forced fans |
| run_normal | output | 1 | Normal operation active |

## Verification
The bench sweeps the number of ticks given before the first access, from zero up to the timeout, and checks that fan_full rises only at the exact limit. A design that was off by one in the compare would force the fans one tick early or late.

Other directed cases target specific faults:
- An access in the very cycle the count expires catches a design that gives expiry priority, which would briefly force the fans.
- Ticks interleaved with idle cycles catch a counter that advances on every clock.
- The rail rising during WAIT catches a sequencer stuck in the unpowered branch.
- Activity after RUN catches a design that re-enters the sequence or repeats the defaults strobe.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
    typedef enum logic [2:0] {
        PS_POLL  = 3'd0,
        PS_WAIT  = 3'd1,
        PS_COUNT = 3'd2,
        PS_FULL  = 3'd3,
        PS_RUN   = 3'd4
    } pwr_state_t;
endpackage

// File: rtl/fsf_timer.sv
module fsf_timer #(
    parameter int TIMEOUT_TICKS = 4600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(TIMEOUT_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM);

    // R11
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
endmodule

// File: rtl/fsf_seq.sv
module fsf_seq
    import fsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_up,
    input  logic bus_hit,
    input  logic expired,
    output logic counting,
    output logic load_dflt,
    output logic fan_full,
    output logic fan_stop,
    output logic run_normal
);
    pwr_state_t st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            PS_POLL: begin
                if (bus_hit)      nxt = PS_RUN;
                else if (rail_up) nxt = PS_COUNT;
                else              nxt = PS_WAIT;
            end
            PS_WAIT: begin
                if (bus_hit)      nxt = PS_RUN;
                else if (rail_up) nxt = PS_COUNT;
            end
            PS_COUNT: begin
                if (bus_hit)      nxt = PS_RUN;
                else if (expired) nxt = PS_FULL;
            end
            PS_FULL: begin
                if (bus_hit)      nxt = PS_RUN;
            end
            PS_RUN:  nxt = PS_RUN;
            default: nxt = PS_POLL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= PS_POLL;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_dflt  <= 1'b0;
            fan_full   <= 1'b0;
            fan_stop   <= 1'b0;
            run_normal <= 1'b0;
        end else begin
            load_dflt  <= (nxt == PS_RUN) && (st != PS_RUN);
            fan_full   <= (nxt == PS_FULL);
            fan_stop   <= (nxt == PS_RUN) && (st == PS_FULL);
            run_normal <= (nxt == PS_RUN);
        end
    end

    assign counting = (st == PS_COUNT);

    // R7
    load_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_dflt |=> !load_dflt);

    // R8
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_normal |=> (run_normal && !load_dflt && !fan_full));

    // R6
    stop_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fan_stop |-> (load_dflt && run_normal && !fan_full));

    // R6
    full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fan_full && run_normal));
endmodule

// File: rtl/fsf_ctrl.sv
module fsf_ctrl #(
    parameter int TIMEOUT_TICKS = 4600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_up,
    input  logic bus_hit,
    input  logic tick,
    output logic load_dflt,
    output logic fan_full,
    output logic fan_stop,
    output logic run_normal
);
    logic counting;
    logic expired;

    fsf_timer #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!counting),
        .tick    (tick),
        .expired (expired)
    );

    fsf_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rail_up    (rail_up),
        .bus_hit    (bus_hit),
        .expired    (expired),
        .counting   (counting),
        .load_dflt  (load_dflt),
        .fan_full   (fan_full),
        .fan_stop   (fan_stop),
        .run_normal (run_normal)
    );
endmodule

// File: tb/fsf_ctrl_test.sv
module fsf_ctrl_test;
    localparam int N = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_up = 1'b0;
    logic bus_hit = 1'b0;
    logic tick = 1'b0;
    logic load_dflt, fan_full, fan_stop, run_normal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fsf_ctrl #(.TIMEOUT_TICKS(N)) uut (
        .clk(clk), .rst_n(rst_n), .rail_up(rail_up), .bus_hit(bus_hit),
        .tick(tick), .load_dflt(load_dflt), .fan_full(fan_full),
        .fan_stop(fan_stop), .run_normal(run_normal)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic ld, input logic ff,
                           input logic fs, input logic rn);
        chk(req, "load_dflt", load_dflt, ld);
        chk(req, "fan_full", fan_full, ff);
        chk(req, "fan_stop", fan_stop, fs);
        chk(req, "run_normal", run_normal, rn);
    endtask

    task automatic cyc(input logic hit, input logic tk);
        bus_hit = hit;
        tick = tk;
        @(posedge clk);
        #1;
        bus_hit = 1'b0;
        tick = 1'b0;
    endtask

    task automatic do_reset(input logic rail);
        rst_n = 1'b0;
        rail_up = rail;
        repeat (2) @(posedge clk);
        #1;
        chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1 / R2: poll cycle, then rail-high countdown swept over tick counts (R4, R5, R6)
        for (int k = 0; k <= N; k++) begin
            do_reset(1'b1);
            cyc(1'b0, 1'b0);
            chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0);
            for (int t = 0; t < k; t++) cyc(1'b0, 1'b1);
            cyc(1'b0, 1'b0);
            chk("R5", "fan_full after ticks", fan_full, (k >= N));
            cyc(1'b1, 1'b0);
            if (k < N) chk_all("R4", 1'b1, 1'b0, 1'b0, 1'b1);
            else       chk_all("R6", 1'b1, 1'b0, 1'b1, 1'b1);
            cyc(1'b0, 1'b0);
            chk_all("R7", 1'b0, 1'b0, 1'b0, 1'b1);
        end

        // R5: fan_full held while host stays silent
        do_reset(1'b1);
        cyc(1'b0, 1'b0);
        for (int t = 0; t < N; t++) cyc(1'b0, 1'b1);
        for (int t = 0; t < 8; t++) begin
            cyc(1'b0, t[0]);
            if (t > 0) chk_all("R5", 1'b0, 1'b1, 1'b0, 1'b0);
        end

        // R2 / R3: rail low waits, ticks ignored, access enters normal
        do_reset(1'b0);
        cyc(1'b0, 1'b0);
        for (int t = 0; t < 3 * N; t++) begin
            cyc(1'b0, 1'b1);
            chk_all("R3", 1'b0, 1'b0, 1'b0, 1'b0);
        end
        cyc(1'b1, 1'b0);
        chk_all("R3", 1'b1, 1'b0, 1'b0, 1'b1);

        // R8: later activity is ignored
        for (int t = 0; t < 12; t++) begin
            rail_up = t[1];
            cyc(t[0], 1'b1);
            chk_all("R8", 1'b0, 1'b0, 1'b0, 1'b1);
        end

        // R2: access during poll goes straight to normal
        do_reset(1'b1);
        cyc(1'b1, 1'b0);
        chk_all("R2", 1'b1, 1'b0, 1'b0, 1'b1);

        // R9: rail rises while waiting
        do_reset(1'b0);
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b1);
        chk("R9", "fan_full while waiting", fan_full, 1'b0);
        rail_up = 1'b1;
        cyc(1'b0, 1'b0);
        for (int t = 0; t < N; t++) cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        chk_all("R9", 1'b0, 1'b1, 1'b0, 1'b0);

        // R10: access coincides with expiry
        do_reset(1'b1);
        cyc(1'b0, 1'b0);
        for (int t = 0; t < N; t++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        chk_all("R10", 1'b1, 1'b0, 1'b0, 1'b1);

        // R11: non-tick cycles do not advance the countdown
        do_reset(1'b1);
        cyc(1'b0, 1'b0);
        for (int t = 0; t < N - 1; t++) begin
            cyc(1'b0, 1'b1);
            for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);
        end
        chk("R11", "fan_full before last tick", fan_full, 1'b0);
        cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
        chk("R11", "fan_full after last tick", fan_full, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule